// File: doc/BRIEF.md
# Longword DMA Channel with Grouped Source Reload

This block is one DMA transfer channel. Each time an external transfer request arrives while the channel is armed, the channel requests the bus. Once the bus is granted, it copies 32-bit longwords from a source address to a destination address. Every copy is a read cycle followed by a write cycle on a bus-master port, and the channel waits for an acknowledge on each cycle. The source and destination addresses are stepped independently after each copy: up by four, down by four, or left unchanged. A transfer counter sets the total number of copies. When the counter reaches zero the channel raises a completion flag, which can drive an interrupt.

In reload mode the channel works in groups of four copies. After the fourth copy of a group, the source address snaps back to the start value that was captured when the channel was armed. The channel then drops its bus request and idles until the next transfer request. The destination keeps stepping across groups, so a repeatedly sampled source (for example a converter result window) fills consecutive memory. Without reload, one request runs the whole count as a single burst while the bus stays held.

Software programs the channel through four word registers. It arms the channel with the enable bit, and it clears the completion flag by writing zero to that flag bit.

Top module: `dma_reload_chan`

## Requirements
- R1: Each copy reads one longword at the source address and then writes that same data to the destination address. Each bus cycle keeps `m_req`, `m_we` and `m_addr` steady until `m_ack` is seen, and `m_req` is only raised while `bus_grant` is high.
- R2: The source mode is CTRL bits [3:2] and the destination mode is CTRL bits [5:4]. Each mode is decoded on its own: 2'b01 steps the address +4 after each copy, 2'b10 steps it -4, and 2'b00 or 2'b11 leave it unchanged.
- R3: With reload on (CTRL bit 6), the fourth copy of each group puts the captured start value back into the source address instead of the next stepped value. This also applies when that fourth copy is the last copy of the count.
- R4: With reload on, the channel drops `bus_req` after each group of four copies (or after the last copy of the count) and starts the next group only on a new `xfer_req`. A count of N therefore needs ceil(N/4) requests.
- R5: With reload off, a single request runs every remaining copy back to back, and `bus_req` stays high without a break until the count is exhausted.
- R6: The destination address is never reloaded. After N copies it reads back as its start value plus N times its step.
- R7: The count register (address 2) falls by one at each completed write. The copy that takes it from 1 to 0 sets the completion flag (CTRL bit 1).
- R8: `irq` is high exactly while the completion flag is set and CTRL bit 7 is set. Writing CTRL with bit 1 at 0 clears the flag, and writing bit 1 at 1 leaves the flag unchanged.
- R9: A request is ignored, and `bus_req` stays low, while the completion flag is set, while CTRL bit 0 (enable) is clear, or while the count is zero.
- R10: After reset, all registers read zero, and `bus_req`, `m_req` and `irq` are low.
- R11: The reload start value is the source register's content at the moment CTRL is written with bit 0 set. A later write to the source register changes where copying begins but not the value reloaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe (ignored while the channel is busy) |
| reg_addr | input | 2 | Register select: 0 source, 1 destination, 2 count, 3 control |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for `reg_addr`, one cycle later |
| xfer_req | input | 1 | Transfer request, sampled while idle |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| m_req | output | 1 | Bus-master cycle request |
| m_we | output | 1 | 1 for the write cycle, 0 for the read cycle |
| m_addr | output | ADDR_W | Bus-master cycle address |
| m_wdata | output | DATA_W | Write data (the longword just read) |
| m_rdata | input | DATA_W | Read data from the slave |
| m_ack | input | 1 | Cycle acknowledge from the slave |
| irq | output | 1 | End-of-transfer interrupt |

## Verification
The bound checker covers the handshake rules on every cycle: a held request keeps its address and direction until the acknowledge, no cycle is issued without the grant, the count falls by one per completed write, the final write sets the completion flag, the interrupt follows the flag, and an idle channel with the flag set never requests the bus. The address sequences need the bench's scenarios, since they depend on a whole run of copies. These include the snap-back of the source on each fourth copy, the destination running on unchanged, the number of requests needed per count, the single unbroken burst without reload, and which value the shadow captured.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_BUSREQ = 2'd1,
    ST_READ   = 2'd2,
    ST_WRITE  = 2'd3
  } xfer_state_e;

  localparam logic [1:0] AM_FIXED = 2'b00;
  localparam logic [1:0] AM_INC   = 2'b01;
  localparam logic [1:0] AM_DEC   = 2'b10;

  localparam logic [1:0] RA_SRC  = 2'd0;
  localparam logic [1:0] RA_DST  = 2'd1;
  localparam logic [1:0] RA_CNT  = 2'd2;
  localparam logic [1:0] RA_CTRL = 2'd3;

  localparam int CB_EN     = 0;
  localparam int CB_DONE   = 1;
  localparam int CB_SMODE  = 2;
  localparam int CB_DMODE  = 4;
  localparam int CB_RELOAD = 6;
  localparam int CB_IRQEN  = 7;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [1:0]        mode,
  output logic [ADDR_W-1:0] nxt
);
  import dma_chan_pkg::*;

  always_comb begin
    unique case (mode)
      AM_INC:  nxt = cur + ADDR_W'(STEP);
      AM_DEC:  nxt = cur - ADDR_W'(STEP);
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              busy,
  input  logic              xfer_done,
  input  logic              reload_now,
  input  logic [ADDR_W-1:0] src_nxt,
  input  logic [ADDR_W-1:0] dst_nxt,
  output logic [ADDR_W-1:0] src_q,
  output logic [ADDR_W-1:0] dst_q,
  output logic [CNT_W-1:0]  cnt_q,
  output logic              en_q,
  output logic              done_q,
  output logic [1:0]        smode_q,
  output logic [1:0]        dmode_q,
  output logic              reload_q,
  output logic              irqen_q
);
  import dma_chan_pkg::*;

  logic [ADDR_W-1:0] shadow_q;
  logic [7:0]        ctrl_view;

  assign ctrl_view = {irqen_q, reload_q, dmode_q, smode_q, done_q, en_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q     <= '0;
      dst_q     <= '0;
      cnt_q     <= '0;
      shadow_q  <= '0;
      en_q      <= 1'b0;
      done_q    <= 1'b0;
      smode_q   <= '0;
      dmode_q   <= '0;
      reload_q  <= 1'b0;
      irqen_q   <= 1'b0;
      reg_rdata <= '0;
    end else begin
      if (reg_we && !busy) begin
        unique case (reg_addr)
          RA_SRC: src_q <= reg_wdata[ADDR_W-1:0];
          RA_DST: dst_q <= reg_wdata[ADDR_W-1:0];
          RA_CNT: cnt_q <= reg_wdata[CNT_W-1:0];
          default: begin
            en_q     <= reg_wdata[CB_EN];
            done_q   <= done_q & reg_wdata[CB_DONE];
            smode_q  <= reg_wdata[CB_SMODE +: 2];
            dmode_q  <= reg_wdata[CB_DMODE +: 2];
            reload_q <= reg_wdata[CB_RELOAD];
            irqen_q  <= reg_wdata[CB_IRQEN];
            if (reg_wdata[CB_EN]) shadow_q <= src_q;
          end
        endcase
      end
      if (xfer_done) begin
        dst_q <= dst_nxt;
        cnt_q <= cnt_q - 1'b1;
        src_q <= reload_now ? shadow_q : src_nxt;
        if (cnt_q == CNT_W'(1)) done_q <= 1'b1;
      end
      unique case (reg_addr)
        RA_SRC:  reg_rdata <= DATA_W'(src_q);
        RA_DST:  reg_rdata <= DATA_W'(dst_q);
        RA_CNT:  reg_rdata <= DATA_W'(cnt_q);
        default: reg_rdata <= DATA_W'(ctrl_view);
      endcase
    end
  end
endmodule

// File: rtl/dma_xfer_fsm.sv
module dma_xfer_fsm #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int GROUP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              xfer_req,
  input  logic              en,
  input  logic              done_flag,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              reload_en,
  input  logic              bus_grant,
  input  logic              m_ack,
  input  logic [DATA_W-1:0] m_rdata,
  output logic              bus_req,
  output logic              m_req,
  output logic              m_we,
  output logic [DATA_W-1:0] data_q,
  output logic              xfer_done,
  output logic              reload_now,
  output logic              busy
);
  import dma_chan_pkg::*;

  localparam int GRP_W = (GROUP > 2) ? $clog2(GROUP) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(GROUP - 1);

  xfer_state_e      st_q, st_d;
  logic [GRP_W-1:0] grp_q;
  logic             last_copy;

  assign last_copy  = (cnt == CNT_W'(1));
  assign reload_now = reload_en && (grp_q == GRP_LAST);
  assign xfer_done  = (st_q == ST_WRITE) && m_ack;
  assign busy       = (st_q != ST_IDLE);
  assign bus_req    = busy;
  assign m_req      = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign m_we       = (st_q == ST_WRITE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (xfer_req && en && !done_flag && cnt != '0) st_d = ST_BUSREQ;
      ST_BUSREQ: if (bus_grant) st_d = ST_READ;
      ST_READ:   if (m_ack) st_d = ST_WRITE;
      default:   if (m_ack) st_d = (last_copy || reload_now) ? ST_IDLE : ST_READ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      grp_q  <= '0;
      data_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_READ && m_ack) data_q <= m_rdata;
      if (xfer_done) grp_q <= (last_copy || reload_now) ? '0 : grp_q + 1'b1;
    end
  end
endmodule

// File: rtl/dma_reload_chan.sv
module dma_reload_chan #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int GROUP  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              xfer_req,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic              m_req,
  output logic              m_we,
  output logic [ADDR_W-1:0] m_addr,
  output logic [DATA_W-1:0] m_wdata,
  input  logic [DATA_W-1:0] m_rdata,
  input  logic              m_ack,
  output logic              irq
);
  localparam int STEP = DATA_W / 8;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              en_q, done_flag, reload_q, irqen_q;
  logic [1:0]        smode_q, dmode_q;
  logic              busy, xfer_done, reload_now;
  logic [ADDR_W-1:0] step_cur  [2];
  logic [1:0]        step_mode [2];
  logic [ADDR_W-1:0] step_nxt  [2];

  assign step_cur[0]  = src_q;
  assign step_mode[0] = smode_q;
  assign step_cur[1]  = dst_q;
  assign step_mode[1] = dmode_q;

  for (genvar g = 0; g < 2; g++) begin : g_step
    dma_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) u_step (
      .cur (step_cur[g]),
      .mode(step_mode[g]),
      .nxt (step_nxt[g])
    );
  end

  dma_chan_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .busy      (busy),
    .xfer_done (xfer_done),
    .reload_now(reload_now),
    .src_nxt   (step_nxt[0]),
    .dst_nxt   (step_nxt[1]),
    .src_q     (src_q),
    .dst_q     (dst_q),
    .cnt_q     (cnt_q),
    .en_q      (en_q),
    .done_q    (done_flag),
    .smode_q   (smode_q),
    .dmode_q   (dmode_q),
    .reload_q  (reload_q),
    .irqen_q   (irqen_q)
  );

  dma_xfer_fsm #(.DATA_W(DATA_W), .CNT_W(CNT_W), .GROUP(GROUP)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .xfer_req  (xfer_req),
    .en        (en_q),
    .done_flag (done_flag),
    .cnt       (cnt_q),
    .reload_en (reload_q),
    .bus_grant (bus_grant),
    .m_ack     (m_ack),
    .m_rdata   (m_rdata),
    .bus_req   (bus_req),
    .m_req     (m_req),
    .m_we      (m_we),
    .data_q    (m_wdata),
    .xfer_done (xfer_done),
    .reload_now(reload_now),
    .busy      (busy)
  );

  assign m_addr = m_we ? dst_q : src_q;
  assign irq    = done_flag && irqen_q;
endmodule

// File: rtl/dma_reload_chan_chk.sv
module dma_reload_chan_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req,
  input logic              bus_grant,
  input logic              m_req,
  input logic              m_we,
  input logic              m_ack,
  input logic [ADDR_W-1:0] m_addr,
  input logic              irq,
  input logic [CNT_W-1:0]  cnt,
  input logic              done_flag
);
  p_hold_until_ack_r1: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> (m_req && $stable(m_we) && $stable(m_addr)));

  p_cycle_needs_grant_r1: assert property (@(posedge clk) disable iff (rst)
    m_req |-> (bus_grant && bus_req));

  p_count_step_r7: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && m_ack) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

  p_flag_on_last_r7: assert property (@(posedge clk) disable iff (rst)
    (m_req && m_we && m_ack && cnt == CNT_W'(1)) |=> done_flag);

  p_irq_follows_flag_r8: assert property (@(posedge clk) disable iff (rst)
    irq |-> done_flag);

  p_flag_blocks_req_r9: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !bus_req) |=> !bus_req);
endmodule

bind dma_reload_chan dma_reload_chan_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_req  (bus_req),
  .bus_grant(bus_grant),
  .m_req    (m_req),
  .m_we     (m_we),
  .m_ack    (m_ack),
  .m_addr   (m_addr),
  .irq      (irq),
  .cnt      (cnt_q),
  .done_flag(done_flag)
);

// File: tb/dma_reload_chan_tb.sv
module dma_reload_chan_tb;
  localparam logic [31:0] KEY = 32'h5A5A_0000;

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] dst;
    logic [15:0] cnt;
    logic [1:0]  sm;
    logic [1:0]  dm;
    logic        rl;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VEC [NV] = '{
    '{32'h0400_0080, 32'h0040_0000, 16'd12,  2'd1, 2'd2, 1'b1},
    '{32'h0400_0080, 32'h0040_0000, 16'd6,   2'd1, 2'd2, 1'b0},
    '{32'h0000_1000, 32'h0000_2000, 16'd5,   2'd0, 2'd1, 1'b0},
    '{32'h0000_3000, 32'h0000_4000, 16'd7,   2'd2, 2'd0, 1'b1},
    '{32'h0000_5000, 32'h0000_6000, 16'd128, 2'd1, 2'd1, 1'b1},
    '{32'h0000_7000, 32'h0000_8000, 16'd3,   2'd3, 2'd2, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic        bus_req, bus_grant, m_req, m_we, m_ack, irq;
  logic [31:0] m_addr, m_wdata, m_rdata;

  int checks = 0;
  int failures = 0;
  logic [31:0] rd_addr [256];
  logic [31:0] wr_addr [256];
  logic [31:0] wr_data [256];
  int nrd = 0, nwr = 0, rises = 0, falls = 0;
  logic prev_bus = 1'b0;
  logic ack_q = 1'b0, grant_q = 1'b0;

  always #4 clk = ~clk;

  dma_reload_chan u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .bus_req(bus_req), .bus_grant(bus_grant), .m_req(m_req), .m_we(m_we),
    .m_addr(m_addr), .m_wdata(m_wdata), .m_rdata(m_rdata), .m_ack(m_ack),
    .irq(irq)
  );

  assign m_rdata   = m_addr ^ KEY;
  assign m_ack     = ack_q;
  assign bus_grant = grant_q;

  always @(posedge clk) begin
    if (m_req && m_ack) begin
      if (m_we) begin
        if (nwr < 256) begin wr_addr[nwr] = m_addr; wr_data[nwr] = m_wdata; end
        nwr++;
      end else begin
        if (nrd < 256) rd_addr[nrd] = m_addr;
        nrd++;
      end
    end
    if (bus_req && !prev_bus) rises++;
    if (!bus_req && prev_bus) falls++;
    prev_bus = bus_req;
    if (rst) begin ack_q <= 1'b0; grant_q <= 1'b0; end
    else begin ack_q <= m_req && !ack_q; grant_q <= bus_req; end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  function automatic int step_of(input logic [1:0] m);
    return (m == 2'd1) ? 4 : (m == 2'd2) ? -4 : 0;
  endfunction

  function automatic logic [31:0] ctrl_word(input logic [1:0] sm, input logic [1:0] dm,
                                            input logic rl, input logic ie, input logic en);
    return {24'd0, ie, rl, dm, sm, 1'b0, en};
  endfunction

  task automatic pulse_req();
    @(negedge clk); xfer_req = 1'b1;
    @(negedge clk); xfer_req = 1'b0;
  endtask

  // Issues requests until the completion flag is set; returns the request count.
  task automatic run_until_done(output int pulses);
    logic [31:0] c;
    pulses = 0;
    for (int p = 0; p < 300; p++) begin
      pulse_req();
      wait (bus_req);
      wait (!bus_req);
      @(negedge clk);
      pulses++;
      rd(2'd3, c);
      if (c[1]) break;
    end
  endtask

  task automatic run_vec(input vec_t v);
    int pulses, f0, sst, dst_s, bad_rd, bad_wa, bad_wd, k, groups;
    logic [31:0] r, exp_src;
    nrd = 0; nwr = 0;
    wr(2'd0, v.src);
    wr(2'd1, v.dst);
    wr(2'd2, 32'(v.cnt));
    wr(2'd3, ctrl_word(v.sm, v.dm, v.rl, 1'b1, 1'b1));
    f0 = falls;
    run_until_done(pulses);
    sst = step_of(v.sm); dst_s = step_of(v.dm);
    bad_rd = 0; bad_wa = 0; bad_wd = 0;
    for (int i = 0; i < int'(v.cnt); i++) begin
      k = v.rl ? (i % 4) : i;
      if (rd_addr[i] !== v.src + 32'(sst * k)) bad_rd++;
      if (wr_addr[i] !== v.dst + 32'(dst_s * i)) bad_wa++;
      if (wr_data[i] !== ((v.src + 32'(sst * k)) ^ KEY)) bad_wd++;
    end
    check(nrd == int'(v.cnt) && nwr == int'(v.cnt), "R7", "copy count", 32'(nwr), 32'(v.cnt));
    check(bad_wd == 0, "R1", "write data mismatches", 32'(bad_wd), 32'd0);
    if (v.rl) check(bad_rd == 0, "R3", "reloaded source sequence", 32'(bad_rd), 32'd0);
    else      check(bad_rd == 0, "R2", "source address sequence", 32'(bad_rd), 32'd0);
    check(bad_wa == 0, "R6", "destination sequence", 32'(bad_wa), 32'd0);
    groups = v.rl ? (int'(v.cnt) + 3) / 4 : 1;
    if (v.rl) check(pulses == groups && falls - f0 == groups, "R4", "groups per request", 32'(pulses), 32'(groups));
    else      check(pulses == 1 && falls - f0 == 1, "R5", "single burst", 32'(falls - f0), 32'd1);
    exp_src = v.src + 32'(sst * (v.rl ? int'(v.cnt) % 4 : int'(v.cnt)));
    rd(2'd0, r); check(r == exp_src, "R3", "final source register", r, exp_src);
    rd(2'd1, r); check(r == v.dst + 32'(dst_s * int'(v.cnt)), "R6", "final destination", r, v.dst + 32'(dst_s * int'(v.cnt)));
    rd(2'd2, r); check(r == 32'd0, "R7", "count at end", r, 32'd0);
    check(irq == 1'b1, "R8", "irq at end", 32'(irq), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int r0, w0, pulses;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10: reset state
    check(!bus_req && !m_req && !irq, "R10", "outputs after reset", {29'd0, bus_req, m_req, irq}, 32'd0);
    rd(2'd3, r); check(r == 32'd0, "R10", "control after reset", r, 32'd0);
    rd(2'd2, r); check(r == 32'd0, "R10", "count after reset", r, 32'd0);
    rd(2'd0, r); check(r == 32'd0, "R10", "source after reset", r, 32'd0);

    // R9: enable clear blocks requests
    wr(2'd2, 32'd2);
    r0 = rises; pulse_req(); repeat (10) @(negedge clk);
    check(rises == r0, "R9", "request with enable clear", 32'(rises - r0), 32'd0);

    for (int n = 0; n < NV; n++) run_vec(VEC[n]);

    // R9: flag still set blocks a new request
    wr(2'd2, 32'd2);
    r0 = rises; w0 = nwr;
    pulse_req(); repeat (20) @(negedge clk);
    check(rises == r0 && nwr == w0, "R9", "request with flag set", 32'(rises - r0), 32'd0);
    // R8: writing 1 to the flag bit keeps it
    wr(2'd3, 32'h0000_0087);
    rd(2'd3, r); check(r[1] == 1'b1, "R8", "flag kept by writing 1", {31'd0, r[1]}, 32'd1);
    // R8: writing 0 clears flag and irq
    wr(2'd3, ctrl_word(2'd1, 2'd1, 1'b0, 1'b1, 1'b1));
    @(negedge clk);
    check(irq == 1'b0, "R8", "irq after clear", 32'(irq), 32'd0);

    // R8: irq disabled keeps irq low while flag sets
    nrd = 0; nwr = 0;
    wr(2'd0, 32'h0000_A000); wr(2'd1, 32'h0000_B000); wr(2'd2, 32'd1);
    wr(2'd3, ctrl_word(2'd1, 2'd1, 1'b0, 1'b0, 1'b1));
    run_until_done(pulses);
    rd(2'd3, r);
    check(r[1] == 1'b1 && irq == 1'b0, "R8", "flag set with irq masked", {30'd0, r[1], irq}, 32'd2);
    wr(2'd3, ctrl_word(2'd1, 2'd1, 1'b0, 1'b0, 1'b0));

    // R11: shadow captured at enable write, later source write not reloaded
    nrd = 0; nwr = 0;
    wr(2'd0, 32'h0000_9000);
    wr(2'd2, 32'd4);
    wr(2'd1, 32'h0000_C000);
    wr(2'd3, ctrl_word(2'd1, 2'd1, 1'b1, 1'b1, 1'b1));
    wr(2'd0, 32'h0000_9100);
    run_until_done(pulses);
    check(rd_addr[0] == 32'h0000_9100 && rd_addr[3] == 32'h0000_910C, "R11", "copy starts at new source", rd_addr[3], 32'h0000_910C);
    rd(2'd0, r); check(r == 32'h0000_9000, "R11", "reload uses captured value", r, 32'h0000_9000);
    check(pulses == 1, "R4", "one group for count 4", 32'(pulses), 32'd1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule